// File: doc/BRIEF.md
# Single-Bank DRAM Read Scheduler

This block drives the command stream of one DRAM bank on behalf of a requester that issues reads. Each request carries a row address, a column address and a tag. The scheduler leaves the most recently activated row open. A request to that row is served straight away with a column read. A request to any other row first closes the open row, waits out the precharge time, activates the new row, waits out the activate-to-read delay, and then issues the column read. Read data is due a fixed number of cycles after every column read, and the scheduler marks that cycle with a valid pulse that carries the tag of the request.

An internal interval timer requests a row refresh on a fixed period, which defaults to a 976 ns interval converted to clock cycles. When a refresh is due, the scheduler stops taking new requests. It lets any accepted request finish, closes the open row once the minimum active time allows, and issues a refresh to the row named by a refresh pointer. The bank stays closed after the refresh. The refresh pointer walks the rows in ascending order and wraps around. All timing limits are parameters counted in clock cycles.

Top module: `dram_bank_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd_o` is NOP (0) and `rd_valid` is low. After reset the bank is closed and `req_ready` is high.
- R2: `cmd_o` carries one command per cycle with the encoding NOP=0, ACT=1, RD=2, PRE=3, REF=4. `cmd_row` gives the row for ACT, RD, PRE and REF, and `cmd_col` gives the column for RD. No other code appears.
- R3: A request accepted at a clock edge, addressed to the open row, produces RD with its row and column in the cycle that begins at that edge.
- R4: A request accepted while the bank is closed produces ACT to its row in the cycle that begins at the accepting edge, then RD exactly T_RCD cycles after the ACT.
- R5: A request to a row other than the open row produces PRE, then ACT T_RP cycles later, then RD T_RCD cycles after that. If the minimum active time allows, the PRE comes in the cycle that begins at the accepting edge, so data is due T_RP+T_RCD+T_CL cycles after that cycle.
- R6: No PRE appears earlier than T_RAS cycles after the preceding ACT. A miss that arrives sooner has its PRE in exactly cycle ACT+T_RAS.
- R7: `rd_valid` pulses for one cycle exactly T_CL cycles after each RD, with `rd_tag` equal to the tag of that request. It is never high otherwise.
- R8: A refresh becomes due every T_REFI cycles. While one is due, `req_ready` is low, so a steady stream of requests cannot keep a refresh from happening.
- R9: A REF is issued only while the bank is closed. An open row is precharged first. After the REF the bank is closed, so the next request takes the ACT path.
- R10: Successive REF commands address rows 0, 1, 2, ... in order, and the row after the last row (2^ROW_W-1) is row 0.
- R11: After a REF, no further command appears for T_RFC cycles.
- R12: Requests that hit the open row are accepted in consecutive cycles, and each produces an RD in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted at this edge when valid is also high |
| req_row | input | ROW_W | Row address of the request |
| req_col | input | COL_W | Column address of the request |
| req_tag | input | TAG_W | Tag returned with the read data |
| cmd_o | output | 3 | Bank command (NOP, ACT, RD, PRE, REF) |
| cmd_row | output | ROW_W | Row for the command |
| cmd_col | output | COL_W | Column for RD |
| rd_valid | output | 1 | Read data due this cycle |
| rd_tag | output | TAG_W | Tag of the read whose data is due |

## Verification
Every command is registered, so the first command of an accepted request shows up in the cycle that begins at the accepting edge. The bench stamps that cycle, works out the cycle of each later PRE, ACT and RD from the timing parameters and from the time of the last ACT it observed, and compares `cmd_o` at every falling edge in between, so an early or a late command shows up as a mismatch. A monitor records the cycle of every RD and expects `rd_valid` with the matching tag exactly T_CL cycles later. It also checks that each PRE, ACT and REF keeps its minimum spacing, measured from the commands it has seen on the ports.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_PRE = 3'd3,
    CMD_REF = 3'd4
  } bank_cmd_e;

  // interval in nanoseconds turned into whole clock cycles
  function automatic int cycles_from_ns(input int ns, input int clk_mhz);
    return (ns * clk_mhz) / 1000;
  endfunction

  // latency from the first command of a row miss to data
  function automatic int miss_cycles(input int rp, input int rcd, input int cl);
    return rp + rcd + cl;
  endfunction

  function automatic int max_wait(input int a, input int b, input int c, input int d);
    return a + b + c + d;
  endfunction

endpackage

// File: rtl/dbs_countdown.sv
module dbs_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/dbs_refresh_timer.sv
module dbs_refresh_timer #(
  parameter int T_REFI = 1561,
  parameter int ROW_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_issued,
  output logic             ref_pend,
  output logic [ROW_W-1:0] ref_row
);
  localparam int TW = $clog2(T_REFI + 1);

  logic [TW-1:0] tcnt;
  logic          tick;

  assign tick = (tcnt == TW'(T_REFI - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt     <= '0;
      ref_pend <= 1'b0;
      ref_row  <= '0;
    end else begin
      tcnt     <= tick ? '0 : tcnt + 1'b1;
      ref_pend <= tick | (ref_pend & ~ref_issued);
      if (ref_issued) ref_row <= ref_row + 1'b1;
    end
  end
endmodule

// File: rtl/dbs_read_pipe.sv
module dbs_read_pipe #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [TAG_W-1:0] push_tag,
  output logic             out_valid,
  output logic [TAG_W-1:0] out_tag
);
  logic             vld [DEPTH];
  logic [TAG_W-1:0] tg  [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) vld[0] <= 1'b0;
    else        vld[0] <= push;
    tg[0] <= push_tag;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) vld[i] <= 1'b0;
      else        vld[i] <= vld[i-1];
      tg[i] <= tg[i-1];
    end
  end

  assign out_valid = vld[DEPTH-1];
  assign out_tag   = tg[DEPTH-1];
endmodule

// File: rtl/dram_bank_sched.sv
module dram_bank_sched
  import dbs_pkg::*;
#(
  parameter int ROW_W   = 16,
  parameter int COL_W   = 10,
  parameter int TAG_W   = 4,
  parameter int T_CL    = 16,
  parameter int T_RCD   = 18,
  parameter int T_RP    = 18,
  parameter int T_RAS   = 36,
  parameter int T_RFC   = 36,
  parameter int REFI_NS = 976,
  parameter int CLK_MHZ = 1600,
  parameter int T_REFI  = cycles_from_ns(REFI_NS, CLK_MHZ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [TAG_W-1:0] req_tag,
  output logic [2:0]       cmd_o,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag
);
  localparam int CW = $clog2(max_wait(T_RAS, T_RFC, T_RP, T_RCD) + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_RAS, ST_TRP, ST_TRCD, ST_REF} st_e;

  st_e              state, nxt_state;
  logic             is_open, for_ref, set_for_ref;
  logic [ROW_W-1:0] open_row, hold_row;
  logic [COL_W-1:0] hold_col;
  logic [TAG_W-1:0] hold_tag;
  bank_cmd_e        issue, cmd_q;
  logic [ROW_W-1:0] issue_row;
  logic [COL_W-1:0] issue_col;
  logic [TAG_W-1:0] issue_tag, cmd_tag_q;
  logic             gap_load, ras_load, gap_zero, ras_done;
  logic [CW-1:0]    gap_val;
  logic             accept, ref_pend, ref_issued, hit;
  logic [ROW_W-1:0] ref_row;

  assign req_ready  = (state == ST_IDLE) && !ref_pend;
  assign accept     = req_valid && req_ready;
  assign hit        = is_open && (req_row == open_row);
  assign ref_issued = (issue == CMD_REF);

  always_comb begin
    nxt_state   = state;
    issue       = CMD_NOP;
    issue_row   = open_row;
    issue_col   = hold_col;
    issue_tag   = hold_tag;
    gap_load    = 1'b0;
    gap_val     = '0;
    ras_load    = 1'b0;
    set_for_ref = 1'b0;
    case (state)
      ST_IDLE: begin
        if (ref_pend) begin
          if (is_open) begin
            set_for_ref = 1'b1;
            if (ras_done) begin
              issue = CMD_PRE; gap_load = 1'b1; gap_val = CW'(T_RP - 1); nxt_state = ST_TRP;
            end else nxt_state = ST_RAS;
          end else begin
            issue = CMD_REF; issue_row = ref_row;
            gap_load = 1'b1; gap_val = CW'(T_RFC - 1); nxt_state = ST_REF;
          end
        end else if (req_valid) begin
          if (hit) begin
            issue = CMD_RD; issue_col = req_col; issue_tag = req_tag;
          end else if (!is_open) begin
            issue = CMD_ACT; issue_row = req_row; ras_load = 1'b1;
            gap_load = 1'b1; gap_val = CW'(T_RCD - 1); nxt_state = ST_TRCD;
          end else if (ras_done) begin
            issue = CMD_PRE; gap_load = 1'b1; gap_val = CW'(T_RP - 1); nxt_state = ST_TRP;
          end else nxt_state = ST_RAS;
        end
      end
      ST_RAS: if (ras_done) begin
        issue = CMD_PRE; gap_load = 1'b1; gap_val = CW'(T_RP - 1); nxt_state = ST_TRP;
      end
      ST_TRP: if (gap_zero) begin
        if (for_ref) begin
          issue = CMD_REF; issue_row = ref_row;
          gap_load = 1'b1; gap_val = CW'(T_RFC - 1); nxt_state = ST_REF;
        end else begin
          issue = CMD_ACT; issue_row = hold_row; ras_load = 1'b1;
          gap_load = 1'b1; gap_val = CW'(T_RCD - 1); nxt_state = ST_TRCD;
        end
      end
      ST_TRCD: if (gap_zero) begin
        issue = CMD_RD; issue_row = hold_row; nxt_state = ST_IDLE;
      end
      ST_REF: if (gap_zero) nxt_state = ST_IDLE;
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      is_open  <= 1'b0;
      open_row <= '0;
      for_ref  <= 1'b0;
      cmd_q    <= CMD_NOP;
    end else begin
      state <= nxt_state;
      cmd_q <= issue;
      if (issue == CMD_ACT) begin
        is_open  <= 1'b1;
        open_row <= issue_row;
      end else if (issue == CMD_PRE) begin
        is_open <= 1'b0;
      end
      if (set_for_ref)       for_ref <= 1'b1;
      else if (ref_issued)   for_ref <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      hold_row <= req_row;
      hold_col <= req_col;
      hold_tag <= req_tag;
    end
    cmd_row   <= issue_row;
    cmd_col   <= issue_col;
    cmd_tag_q <= issue_tag;
  end

  assign cmd_o = cmd_q;

  dbs_countdown #(.W(CW)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(gap_val), .zero(gap_zero)
  );

  dbs_countdown #(.W(CW)) u_ras (
    .clk(clk), .rst_n(rst_n), .load(ras_load), .load_val(CW'(T_RAS - 1)), .zero(ras_done)
  );

  dbs_refresh_timer #(.T_REFI(T_REFI), .ROW_W(ROW_W)) u_refi (
    .clk(clk), .rst_n(rst_n), .ref_issued(ref_issued), .ref_pend(ref_pend), .ref_row(ref_row)
  );

  dbs_read_pipe #(.DEPTH(T_CL), .TAG_W(TAG_W)) u_rpipe (
    .clk(clk), .rst_n(rst_n), .push(cmd_q == CMD_RD), .push_tag(cmd_tag_q),
    .out_valid(rd_valid), .out_tag(rd_tag)
  );
endmodule

// File: rtl/dbs_checker.sv
module dbs_checker #(
  parameter int ROW_W = 16,
  parameter int T_CL  = 16,
  parameter int T_RCD = 18,
  parameter int T_RP  = 18,
  parameter int T_RAS = 36,
  parameter int T_RFC = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cmd_o,
  input logic [ROW_W-1:0] cmd_row,
  input logic             req_ready,
  input logic             rd_valid,
  input logic             ref_pend,
  input logic             is_open
);
  localparam int OW = $clog2(T_CL + 2) + 1;

  logic [15:0]      since_act, since_pre, since_ref;
  logic             seen_act, seen_pre, seen_ref;
  logic [ROW_W-1:0] last_ref_row;
  logic [OW-1:0]    outstanding;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= '0; since_pre <= '0; since_ref <= '0;
      seen_act <= 1'b0; seen_pre <= 1'b0; seen_ref <= 1'b0;
      last_ref_row <= '0;
      outstanding  <= '0;
    end else begin
      since_act <= (cmd_o == 3'd1) ? '0 : (since_act == 16'hFFFF ? since_act : since_act + 1'b1);
      since_pre <= (cmd_o == 3'd3) ? '0 : (since_pre == 16'hFFFF ? since_pre : since_pre + 1'b1);
      since_ref <= (cmd_o == 3'd4) ? '0 : (since_ref == 16'hFFFF ? since_ref : since_ref + 1'b1);
      if (cmd_o == 3'd1) seen_act <= 1'b1;
      if (cmd_o == 3'd3) seen_pre <= 1'b1;
      if (cmd_o == 3'd4) begin
        seen_ref     <= 1'b1;
        last_ref_row <= cmd_row;
      end
      outstanding <= outstanding + OW'(cmd_o == 3'd2) - OW'(rd_valid);
    end
  end

  // R2
  cmd_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_o <= 3'd4);

  // R4
  act_to_rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 3'd2 && seen_act) |-> since_act >= 16'(T_RCD - 1));

  // R5
  pre_to_act_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 3'd1 && seen_pre) |-> since_pre >= 16'(T_RP - 1));

  // R6
  ras_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 3'd3) |-> (seen_act && since_act >= 16'(T_RAS - 1)));

  // R7
  no_orphan_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> outstanding != '0);

  // R8
  ref_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend |-> !req_ready);

  // R9
  ref_on_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 3'd4) |-> !is_open);

  // R10
  ref_row_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 3'd4 && seen_ref) |-> cmd_row == ROW_W'(last_ref_row + 1'b1));

  // R11
  ref_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != 3'd0 && seen_ref) |-> since_ref >= 16'(T_RFC - 1));
endmodule

bind dram_bank_sched dbs_checker #(
  .ROW_W(ROW_W), .T_CL(T_CL), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RFC(T_RFC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_o(cmd_o), .cmd_row(cmd_row), .req_ready(req_ready),
  .rd_valid(rd_valid), .ref_pend(ref_pend), .is_open(is_open)
);

// File: tb/dram_bank_sched_tb.sv
module dram_bank_sched_tb;
  localparam int ROW_W = 2, COL_W = 4, TAG_W = 4;
  localparam int CL = 3, RCD = 4, RP = 5, RAS = 9, RFC = 6, REFI = 150;
  localparam int NROWS = 1 << ROW_W;
  localparam int K_CLOSED = 0, K_HIT = 1, K_MISS = 2;
  localparam int NVEC = 10;
  // row, col, tag, expected path (0 closed, 1 hit, 2 miss)
  localparam logic [11:0] VEC [NVEC] = '{
    {2'd1, 4'd3, 4'd1, 2'd0}, {2'd1, 4'd5, 4'd2, 2'd1}, {2'd1, 4'd6, 4'd3, 2'd1},
    {2'd2, 4'd1, 4'd4, 2'd2}, {2'd2, 4'd2, 4'd5, 2'd1}, {2'd3, 4'd7, 4'd6, 2'd2},
    {2'd0, 4'd0, 4'd7, 2'd2}, {2'd0, 4'd9, 4'd8, 2'd1}, {2'd3, 4'd15, 4'd9, 2'd2},
    {2'd3, 4'd4, 4'd10, 2'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [ROW_W-1:0] req_row = '0, cmd_row;
  logic [COL_W-1:0] req_col = '0, cmd_col;
  logic [TAG_W-1:0] req_tag = '0, rd_tag;
  logic [2:0] cmd_o;
  logic rd_valid;

  dram_bank_sched #(.ROW_W(ROW_W), .COL_W(COL_W), .TAG_W(TAG_W), .T_CL(CL), .T_RCD(RCD),
    .T_RP(RP), .T_RAS(RAS), .T_RFC(RFC), .T_REFI(REFI)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_tag(req_tag), .cmd_o(cmd_o),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .rd_valid(rd_valid), .rd_tag(rd_tag));

  always #5 clk = ~clk;

  int cyc = 0, errors = 0, checks = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // bench model of the bank, built from observed commands only
  bit m_open = 1'b0;
  int m_row = 0, t_act = -1000, t_pre = -1000, t_ref = -1000, ref_cnt = 0, ref_exp = 0;
  logic [TAG_W-1:0] acc_tag [64];
  int acc_wr = 0, acc_rd = 0;
  int due_cyc [64];
  logic [TAG_W-1:0] due_tag [64];
  int due_wr = 0, due_rd = 0;

  always @(negedge clk) if (rst_n) begin
    if (cmd_o != 3'd0 && ref_cnt > 0 && cmd_o != 3'd4)
      chk(cyc >= t_ref + RFC, "R11 quiet after REF", cyc - t_ref, RFC);
    case (cmd_o)
      3'd1: begin
        chk(cyc - t_pre >= RP, "R5 PRE->ACT spacing", cyc - t_pre, RP);
        m_open = 1'b1; m_row = int'(cmd_row); t_act = cyc;
      end
      3'd2: begin
        chk(m_open && int'(cmd_row) == m_row, "R3 RD to open row", int'(cmd_row), m_row);
        due_cyc[due_wr % 64] = cyc + CL;
        due_tag[due_wr % 64] = acc_tag[acc_rd % 64];
        due_wr++; acc_rd++;
      end
      3'd3: begin
        chk(cyc - t_act >= RAS, "R6 ACT->PRE spacing", cyc - t_act, RAS);
        m_open = 1'b0; t_pre = cyc;
      end
      3'd4: begin
        chk(!m_open, "R9 REF on closed bank", int'(m_open), 0);
        chk(int'(cmd_row) == ref_exp, "R10 refresh row order", int'(cmd_row), ref_exp);
        ref_exp = (ref_exp + 1) % NROWS; ref_cnt++; t_ref = cyc;
      end
      default: ;
    endcase
    if (rd_valid || (due_rd != due_wr && due_cyc[due_rd % 64] == cyc)) begin
      chk(rd_valid && due_rd != due_wr && due_cyc[due_rd % 64] == cyc,
          "R7 data valid timing", int'(rd_valid), 1);
      if (due_rd != due_wr) begin
        chk(rd_tag == due_tag[due_rd % 64], "R7 data tag", int'(rd_tag), int'(due_tag[due_rd % 64]));
        due_rd++;
      end
    end
  end

  task automatic do_req(input int row, input int col, input int tag, input int kind_tab);
    int kind, ta, acc, pre_at, act_at, rd_at, exp;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    kind = !m_open ? K_CLOSED : (m_row == row ? K_HIT : K_MISS);
    if (m_open) chk(kind == kind_tab, "R3 path from table", kind, kind_tab);
    ta = t_act;
    req_valid = 1'b1; req_row = ROW_W'(row); req_col = COL_W'(col); req_tag = TAG_W'(tag);
    acc_tag[acc_wr % 64] = TAG_W'(tag); acc_wr++;
    @(negedge clk);
    req_valid = 1'b0;
    acc = cyc;
    pre_at = -1; act_at = -1;
    if (kind == K_HIT) rd_at = acc;
    else if (kind == K_CLOSED) begin act_at = acc; rd_at = acc + RCD; end
    else begin
      pre_at = (ta + RAS > acc) ? ta + RAS : acc;
      act_at = pre_at + RP; rd_at = act_at + RCD;
    end
    forever begin
      exp = (cyc == rd_at) ? 2 : (cyc == act_at) ? 1 : (cyc == pre_at) ? 3 : 0;
      if (kind == K_HIT) chk(int'(cmd_o) == exp, "R3 hit command", int'(cmd_o), exp);
      else if (kind == K_CLOSED) chk(int'(cmd_o) == exp, "R4 closed-bank command", int'(cmd_o), exp);
      else chk(int'(cmd_o) == exp, "R5 R6 miss command", int'(cmd_o), exp);
      if (cyc == act_at) chk(int'(cmd_row) == row, "R4 ACT row", int'(cmd_row), row);
      if (cyc == rd_at) begin
        chk(int'(cmd_col) == col, "R2 RD column", int'(cmd_col), col);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic stream_hits(input int n, output int hits);
    bit prev = 1'b0;
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (prev) chk(cmd_o == 3'd2, "R12 back-to-back hit RD", int'(cmd_o), 2);
      req_valid = 1'b0; prev = 1'b0;
      if (req_ready && m_open) begin
        req_valid = 1'b1; req_row = ROW_W'(m_row); req_col = COL_W'(i); req_tag = TAG_W'(i);
        acc_tag[acc_wr % 64] = TAG_W'(i); acc_wr++;
        prev = 1'b1; hits++;
      end else if (req_ready) begin
        do_req(1, 2, 11, K_CLOSED);
      end
    end
    @(negedge clk);
    if (prev) chk(cmd_o == 3'd2, "R12 back-to-back hit RD", int'(cmd_o), 2);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired at cycle %0d: actual=0 expected=1", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int hits, refs0, row0;
    repeat (3) @(negedge clk);
    chk(cmd_o == 3'd0, "R1 NOP in reset", int'(cmd_o), 0);
    chk(rd_valid == 1'b0, "R1 no data in reset", int'(rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_o == 3'd0, "R1 NOP after reset", int'(cmd_o), 0);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);

    for (int v = 0; v < NVEC; v++)
      do_req(int'(VEC[v][11:10]), int'(VEC[v][9:6]), int'(VEC[v][5:2]), int'(VEC[v][1:0]));

    // R9: bank closed after a refresh, next request activates
    refs0 = ref_cnt; row0 = m_row;
    while (ref_cnt == refs0) @(negedge clk);
    chk(!m_open, "R9 closed after REF", int'(m_open), 0);
    do_req(row0, 4, 12, K_CLOSED);

    // R8, R12: steady hit stream does not starve refresh
    refs0 = ref_cnt;
    stream_hits(400, hits);
    chk(hits > 100, "R12 hits accepted in stream", hits, 101);
    chk(ref_cnt - refs0 >= 2, "R8 refresh under load", ref_cnt - refs0, 2);

    repeat (300) @(negedge clk);
    chk(ref_cnt >= NROWS + 1, "R10 pointer wrapped", ref_cnt, NROWS + 1);
    chk(ref_cnt >= cyc / REFI - 1 && ref_cnt <= cyc / REFI, "R8 refresh rate", ref_cnt, cyc / REFI);
    chk(due_rd == due_wr, "R7 all data returned", due_rd, due_wr);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule